// File: doc/BRIEF.md
# Flash Busy-Status Output Generator

This block sits in the read path of a parallel flash device. It watches the chip-enable, write-enable and output-enable strobes, all active low and sampled on the system clock. It counts the bus write cycles of a command sequence. Once the sequence has run long enough for its operation type, the block is armed. From then on, for as long as the internal write timer reports busy, the block replaces two bits of the read word with status information.

For a program operation, the polling bit reads back as the complement of the bit being programmed. For any erase, it reads back as zero. A second bit flips on every read strobe, so software can tell that the part is busy by comparing two consecutive reads. When the timer drops busy, the array word passes through untouched, the sequence is considered complete, and the pulse counter starts again from zero.

Top module: `flash_status_gen`

## Requirements
- R1: Whenever the block is not armed, or `busy` is low, `rd_data` equals `arr_data` in every bit.
- R2: Armed program with `busy` high: `rd_data[7]` is the inverse of `prog_bit` as sampled on the arming write pulse. Bits other than 7 and 6 come from `arr_data`.
- R3: Armed erase (`op_kind` 01 sector, 10 block, 11 chip) with `busy` high: `rd_data[7]` is 0. Bits other than 7 and 6 come from `arr_data`.
- R4: Armed with `busy` high: `rd_data[6]` starts at 0 and inverts on each read. A read is a falling edge of `oe_n` while `ce_n` is low, so the first read returns 1. Without such a read the bit holds, and an `oe_n` fall while `ce_n` is high does not advance it.
- R5: Program (`op_kind` 00) arms on the 4th counted write pulse. Erase arms on the 6th. With fewer pulses, `busy` high has no effect on `rd_data`.
- R6: A write pulse is the overlap of `ce_n` low and `we_n` low. It is counted when whichever of the two rises first ends it.
- R7: A write overlap during which `oe_n` is low is not counted.
- R8: After arming, the first cycle with `busy` low that follows a cycle with `busy` high completes the sequence. The count returns to zero, so the next sequence needs the full number of pulses again, and the toggle bit restarts at 0.
- R9: After reset the block is unarmed with a zero count, so `rd_data` equals `arr_data` even while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 block erase, 11 chip erase |
| prog_bit | input | 1 | Bit 7 of the word being programmed |
| busy | input | 1 | Internal write timer running |
| arr_data | input | 16 | Word read from the array |
| rd_data | output | 16 | Word driven onto the bus |

## Verification
The bench builds the block with its default parameters: a 16-bit word, polling on bit 7, toggling on bit 6, and thresholds of 4 and 6 pulses. With these values, both arming thresholds and all four operation codes can be reached in a few dozen cycles per sequence. Randomised sequences mix write pulses ended by either strobe, inhibited pulses, and reads issued with chip enable high. Each sequence is checked before arming, while armed but idle, and across several status reads.

// File: rtl/flash_status_pkg.sv
`timescale 1ns/1ps
package flash_status_pkg;

    typedef enum logic [1:0] {
        OP_PROGRAM      = 2'b00,
        OP_SECTOR_ERASE = 2'b01,
        OP_BLOCK_ERASE  = 2'b10,
        OP_CHIP_ERASE   = 2'b11
    } op_kind_e;

    typedef struct packed {
        logic wr_act;
        logic oe_hi;
    } strobe_st_t;

    function automatic logic is_erase(input op_kind_e k);
        return k != OP_PROGRAM;
    endfunction

endpackage

// File: rtl/flash_strobe_edge.sv
`timescale 1ns/1ps
module flash_strobe_edge
    import flash_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_end,
    output logic rd_start
);

    strobe_st_t st_d, st_q;
    logic       wr_now;

    always_comb begin
        // a write overlap only counts while output enable is idle
        wr_now       = !ce_n && !we_n && oe_n;
        st_d.wr_act  = wr_now;
        st_d.oe_hi   = oe_n;
        wr_end       = st_q.wr_act && !wr_now;
        rd_start     = st_q.oe_hi && !oe_n && !ce_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wr_act <= 1'b0;
            st_q.oe_hi  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/flash_seq_tracker.sv
`timescale 1ns/1ps
module flash_seq_tracker
    import flash_status_pkg::*;
#(
    parameter int PROG_PULSES  = 4,
    parameter int ERASE_PULSES = 6,
    parameter int CNT_W        = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_end,
    input  logic [1:0]       op_kind,
    input  logic             prog_bit,
    input  logic             busy,
    output logic             armed,
    output logic             erase_lat,
    output logic             bit_lat,
    output logic [CNT_W-1:0] pulse_cnt
);

    localparam logic [CNT_W-1:0] NEED_PROG  = CNT_W'(PROG_PULSES);
    localparam logic [CNT_W-1:0] NEED_ERASE = CNT_W'(ERASE_PULSES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             seen_busy;
        logic             erase;
        logic             bitv;
    } trk_st_t;

    trk_st_t          st_d, st_q;
    op_kind_e         op_e;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        op_e    = op_kind_e'(op_kind);
        need    = is_erase(op_e) ? NEED_ERASE : NEED_PROG;
        cnt_inc = st_q.cnt + CNT_W'(1);
        if (!st_q.armed) begin
            if (wr_end) begin
                if (cnt_inc >= need) begin
                    st_d.armed     = 1'b1;
                    st_d.cnt       = need;
                    st_d.erase     = is_erase(op_e);
                    st_d.bitv      = prog_bit;
                    st_d.seen_busy = 1'b0;
                end else begin
                    st_d.cnt = cnt_inc;
                end
            end
        end else if (busy) begin
            st_d.seen_busy = 1'b1;
        end else if (st_q.seen_busy) begin
            // timer finished: sequence complete
            st_d.armed     = 1'b0;
            st_d.cnt       = '0;
            st_d.seen_busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed     = st_q.armed;
    assign erase_lat = st_q.erase;
    assign bit_lat   = st_q.bitv;
    assign pulse_cnt = st_q.cnt;

endmodule

// File: rtl/flash_toggle_gen.sv
`timescale 1ns/1ps
module flash_toggle_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rd_start,
    output logic tog
);

    logic tog_d, tog_q;

    always_comb begin
        if (!active)       tog_d = 1'b0;
        else if (rd_start) tog_d = !tog_q;
        else               tog_d = tog_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    assign tog = tog_q;

endmodule

// File: rtl/flash_rd_mux.sv
`timescale 1ns/1ps
module flash_rd_mux #(
    parameter int DATA_W   = 16,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic [DATA_W-1:0] arr_data,
    input  logic              active,
    input  logic              erase_lat,
    input  logic              bit_lat,
    input  logic              tog,
    output logic [DATA_W-1:0] rd_data
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == POLL_BIT) begin : g_poll
            assign rd_data[i] = active ? (!erase_lat && !bit_lat) : arr_data[i];
        end else if (i == TOG_BIT) begin : g_tog
            assign rd_data[i] = active ? tog : arr_data[i];
        end else begin : g_pass
            assign rd_data[i] = arr_data[i];
        end
    end

endmodule

// File: rtl/flash_status_gen.sv
`timescale 1ns/1ps
module flash_status_gen #(
    parameter int DATA_W       = 16,
    parameter int POLL_BIT     = 7,
    parameter int TOG_BIT      = 6,
    parameter int PROG_PULSES  = 4,
    parameter int ERASE_PULSES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [1:0]        op_kind,
    input  logic              prog_bit,
    input  logic              busy,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int CNT_W = $clog2(ERASE_PULSES + 1);

    logic             wr_end;
    logic             rd_start;
    logic             armed;
    logic             erase_lat;
    logic             bit_lat;
    logic [CNT_W-1:0] pulse_cnt;
    logic             status_on;
    logic             tog;

    flash_strobe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .wr_end   (wr_end),
        .rd_start (rd_start)
    );

    flash_seq_tracker #(
        .PROG_PULSES  (PROG_PULSES),
        .ERASE_PULSES (ERASE_PULSES),
        .CNT_W        (CNT_W)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_end    (wr_end),
        .op_kind   (op_kind),
        .prog_bit  (prog_bit),
        .busy      (busy),
        .armed     (armed),
        .erase_lat (erase_lat),
        .bit_lat   (bit_lat),
        .pulse_cnt (pulse_cnt)
    );

    assign status_on = armed && busy;

    flash_toggle_gen u_tog (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (status_on),
        .rd_start (rd_start),
        .tog      (tog)
    );

    flash_rd_mux #(
        .DATA_W   (DATA_W),
        .POLL_BIT (POLL_BIT),
        .TOG_BIT  (TOG_BIT)
    ) u_mux (
        .arr_data  (arr_data),
        .active    (status_on),
        .erase_lat (erase_lat),
        .bit_lat   (bit_lat),
        .tog       (tog),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/flash_status_gen_chk.sv
`timescale 1ns/1ps
module flash_status_gen_chk #(
    parameter int DATA_W       = 16,
    parameter int POLL_BIT     = 7,
    parameter int TOG_BIT      = 6,
    parameter int PROG_PULSES  = 4,
    parameter int ERASE_PULSES = 6,
    parameter int CNT_W        = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              armed,
    input logic              erase_lat,
    input logic              bit_lat,
    input logic              rd_start,
    input logic [CNT_W-1:0]  pulse_cnt,
    input logic [DATA_W-1:0] arr_data,
    input logic [DATA_W-1:0] rd_data
);

    a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && busy) |-> rd_data == arr_data);

    a_r2_prog_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && busy && !erase_lat) |-> rd_data[POLL_BIT] == !bit_lat);

    a_r3_erase_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && busy && erase_lat) |-> !rd_data[POLL_BIT]);

    a_r4_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && busy && rd_start) |=>
            (!(armed && busy) || rd_data[TOG_BIT] != $past(rd_data[TOG_BIT])));

    a_r4_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && busy && !rd_start) |=>
            (!(armed && busy) || $stable(rd_data[TOG_BIT])));

    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= CNT_W'(ERASE_PULSES));

    a_r5_arm_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> ($past(pulse_cnt) == CNT_W'(PROG_PULSES - 1) ||
                          $past(pulse_cnt) == CNT_W'(ERASE_PULSES - 1)));

    a_r8_clear_count: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(armed) |-> pulse_cnt == '0);

endmodule

bind flash_status_gen flash_status_gen_chk #(
    .DATA_W       (DATA_W),
    .POLL_BIT     (POLL_BIT),
    .TOG_BIT      (TOG_BIT),
    .PROG_PULSES  (PROG_PULSES),
    .ERASE_PULSES (ERASE_PULSES),
    .CNT_W        (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .armed     (armed),
    .erase_lat (erase_lat),
    .bit_lat   (bit_lat),
    .rd_start  (rd_start),
    .pulse_cnt (pulse_cnt),
    .arr_data  (arr_data),
    .rd_data   (rd_data)
);

// File: tb/flash_status_gen_tb.sv
`timescale 1ns/1ps
module flash_status_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ce_n, we_n, oe_n;
    logic [1:0]  op_kind;
    logic        prog_bit;
    logic        busy;
    logic [15:0] arr_data;
    logic [15:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    flash_status_gen u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .op_kind  (op_kind),
        .prog_bit (prog_bit),
        .busy     (busy),
        .arr_data (arr_data),
        .rd_data  (rd_data)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] status_word(input logic [15:0] arr, input bit erase,
                                                input bit d7, input bit tg);
        logic [15:0] w;
        w    = arr;
        w[7] = erase ? 1'b0 : !d7;
        w[6] = tg;
        return w;
    endfunction

    // one write pulse; ended by we_n (use_ce=0) or by ce_n (use_ce=1)
    task automatic wr_pulse(input bit use_ce, input bit oe_low);
        if (!use_ce) begin
            we_n = 1'b0;
            oe_n = oe_low ? 1'b0 : 1'b1;
            @(negedge clk);
            @(negedge clk);
            we_n = 1'b1;
            oe_n = 1'b1;
            @(negedge clk);
        end else begin
            ce_n = 1'b1;
            we_n = 1'b0;
            @(negedge clk);
            ce_n = 1'b0;
            @(negedge clk);
            @(negedge clk);
            ce_n = 1'b1;
            @(negedge clk);
            we_n = 1'b1;
            ce_n = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic do_read(output logic [15:0] v, input bit ce_high);
        ce_n = ce_high;
        oe_n = 1'b0;
        @(negedge clk);
        v    = rd_data;
        oe_n = 1'b1;
        ce_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_seq(input logic [1:0] op, input bit use_ce, input bit d7,
                           input bit inhibit, input int nreads);
        int          need;
        bit          erase;
        bit          tg;
        logic [15:0] v;
        erase    = (op != 2'b00);
        need     = erase ? 6 : 4;
        op_kind  = op;
        prog_bit = d7;
        for (int i = 0; i < need - 1; i++) wr_pulse(use_ce, 1'b0);
        if (inhibit) wr_pulse(1'b0, 1'b1);
        busy     = 1'b1;
        arr_data = 16'($urandom);
        @(negedge clk);
        check(inhibit ? "R7 inhibited pulse counted" : "R5 R8 armed too early", rd_data, arr_data);
        busy = 1'b0;
        @(negedge clk);
        wr_pulse(use_ce, 1'b0);
        arr_data = 16'($urandom);
        @(negedge clk);
        check("R1 armed but idle", rd_data, arr_data);
        busy = 1'b1;
        @(negedge clk);
        tg = 1'b0;
        check(use_ce ? "R6 ce-ended pulse arming" : (erase ? "R3 status before read" : "R2 status before read"),
              rd_data, status_word(arr_data, erase, d7, tg));
        for (int r = 0; r < nreads; r++) begin
            arr_data = 16'($urandom);
            if (r == 1) begin
                do_read(v, 1'b1);
                check("R4 read with ce high", v, status_word(arr_data, erase, d7, tg));
            end
            tg = !tg;
            do_read(v, 1'b0);
            check(erase ? "R3 R4 erase status read" : "R2 R4 program status read",
                  v, status_word(arr_data, erase, d7, tg));
            @(negedge clk);
            check("R4 hold without read", rd_data, status_word(arr_data, erase, d7, tg));
        end
        busy = 1'b0;
        @(negedge clk);
        check("R1 R8 done passthrough", rd_data, arr_data);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1f3a_5eed));
        rst_n = 1'b0; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
        op_kind = 2'b00; prog_bit = 1'b0; busy = 1'b0; arr_data = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        arr_data = 16'hA5C3;
        busy = 1'b1;
        @(negedge clk);
        check("R9 reset state passthrough", rd_data, 16'hA5C3);
        busy = 1'b0;
        @(negedge clk);

        // directed corners
        run_seq(2'b00, 1'b0, 1'b1, 1'b0, 4);   // program, bit 7 = 1
        run_seq(2'b00, 1'b0, 1'b0, 1'b0, 3);   // program, bit 7 = 0
        run_seq(2'b01, 1'b0, 1'b1, 1'b0, 3);   // sector erase
        run_seq(2'b10, 1'b1, 1'b0, 1'b0, 2);   // block erase, ce-ended pulses
        run_seq(2'b11, 1'b0, 1'b1, 1'b1, 3);   // chip erase with inhibited pulse
        run_seq(2'b00, 1'b1, 1'b1, 1'b1, 2);   // program via ce, inhibited pulse

        for (int k = 0; k < 30; k++) begin
            run_seq(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
                    1'($urandom % 2), 1 + int'($urandom % 4));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule